// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block performs integer multiplication and division on two operands, signed or unsigned, at a narrow width (the low halves of the operand buses) or at the full bus width. A caller pulses a start strobe together with three mode bits and the two operands. The unit then runs that single operation for a fixed number of cycles, chosen by the mode, and pulses a completion flag. It takes no second operation while one is in flight.

Results land in two registers. For a product, the low half of the full-width product goes to the low register and the upper half goes to the high register. For a quotient, the quotient goes to the low register and the remainder to the high register. Narrow-width results are always sign-extended to the full register width. Both registers keep their value until the next completion.

Top module: `muldiv_unit`

## Requirements
- R1: A start asserted while busy_o is high is ignored. The running operation finishes at its own time with its own results, and no extra completion follows.
- R2: A narrow multiply (div_i=0, wide_i=0) raises done_o 10 clock edges after the edge that sampled start_i.
- R3: A wide multiply (div_i=0, wide_i=1) raises done_o 20 edges after the start edge.
- R4: A narrow divide (div_i=1, wide_i=0) raises done_o 69 edges after the start edge.
- R5: A wide divide (div_i=1, wide_i=1) raises done_o 133 edges after the start edge.
- R6: busy_o is high from the cycle after an accepted start until the completion cycle. In the completion cycle busy_o is low and done_o is high for exactly one cycle.
- R7: For a multiply, lo_o holds the low half of the product and hi_o the high half. signed_i=1 treats the operands as two's complement and signed_i=0 treats them as unsigned.
- R8: For a divide, lo_o holds the quotient and hi_o the remainder. A signed quotient truncates toward zero, and a nonzero remainder carries the sign of the dividend.
- R9: A divide by zero finishes with the normal latency and gives an all-ones quotient and a remainder equal to the dividend.
- R10: With wide_i=0, only bits 31:0 of each operand are used. Both results are the 32-bit values sign-extended to 64 bits.
- R11: After reset, busy_o, done_o, hi_o and lo_o are all zero. hi_o and lo_o keep their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when not busy |
| div_i | input | 1 | 1 = divide, 0 = multiply |
| signed_i | input | 1 | 1 = two's complement operands |
| wide_i | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| a_i | input | 64 | Multiplicand or dividend |
| b_i | input | 64 | Multiplier or divisor |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 64 | High product half or remainder |
| lo_o | output | 64 | Low product half or quotient |

## Verification
Each result is due a fixed number of edges after the edge that sampled start: 10, 20, 69 or 133, depending on the multiply or divide and narrow or wide selection. The bench drives inputs on falling edges. It then counts rising edges from the start edge until done_o shows at a falling edge, and compares that count with the expected latency. The bench reads hi_o and lo_o in that same completion cycle, checks busy_o at every falling edge in between, and checks that done_o is low one cycle later. An ignored start is checked by confirming that the first operation still completes at its own latency with its own results, and that no completion appears in the 150 cycles after it.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef struct packed {
        logic is_div;
        logic sgn;
        logic wide;
    } md_op_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
    parameter int MUL_N_LAT = 10,
    parameter int MUL_W_LAT = 20,
    parameter int DIV_N_LAT = 69,
    parameter int DIV_W_LAT = 133
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic is_div_i,
    input  logic wide_i,
    output logic accept_o,
    output logic fire_o,
    output logic busy_o,
    output logic done_o
);
    localparam int MAX_LAT = DIV_W_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [CNT_W-1:0] lat_m1;

    always_comb begin
        if (is_div_i) lat_m1 = wide_i ? CNT_W'(DIV_W_LAT - 1) : CNT_W'(DIV_N_LAT - 1);
        else          lat_m1 = wide_i ? CNT_W'(MUL_W_LAT - 1) : CNT_W'(MUL_N_LAT - 1);
    end

    assign accept_o = start_i && !st_q.busy;
    assign fire_o   = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (fire_o) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (accept_o) begin
            st_d.busy = 1'b1;
            st_d.cnt  = lat_m1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

    // R1: a start seen mid-operation does not restart or end the operation early
    a_r1_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i && !fire_o) |=> (busy_o && !done_o));

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the counter only runs while busy
    a_r6_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
    parameter int XLEN = 64
) (
    input  logic            sgn_i,
    input  logic            wide_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0]   a_n, b_n, prod_n;
    logic [2*XLEN-1:0] a_w, b_w, prod_w;

    always_comb begin
        a_n    = {{HALF{sgn_i & a_i[HALF-1]}}, a_i[HALF-1:0]};
        b_n    = {{HALF{sgn_i & b_i[HALF-1]}}, b_i[HALF-1:0]};
        prod_n = a_n * b_n;
        a_w    = {{XLEN{sgn_i & a_i[XLEN-1]}}, a_i};
        b_w    = {{XLEN{sgn_i & b_i[XLEN-1]}}, b_i};
        prod_w = a_w * b_w;
        if (wide_i) begin
            hi_o = prod_w[2*XLEN-1:XLEN];
            lo_o = prod_w[XLEN-1:0];
        end else begin
            hi_o = {{HALF{prod_n[XLEN-1]}}, prod_n[XLEN-1:HALF]};
            lo_o = {{HALF{prod_n[HALF-1]}}, prod_n[HALF-1:0]};
        end
    end

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            sgn_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            ready_o,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o
);
    localparam int CW = $clog2(XLEN + 1);

    typedef struct packed {
        logic [XLEN-1:0] rem;
        logic [XLEN-1:0] quo;
        logic [XLEN-1:0] dvs;
        logic [CW-1:0]   cnt;
        logic            neg_q;
        logic            neg_r;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [XLEN:0] shl, diff;

    always_comb begin
        st_d = st_q;
        shl  = {st_q.rem, st_q.quo[XLEN-1]};
        diff = shl - {1'b0, st_q.dvs};
        if (load_i) begin
            st_d.rem   = '0;
            st_d.quo   = (sgn_i && a_i[XLEN-1]) ? -a_i : a_i;
            st_d.dvs   = (sgn_i && b_i[XLEN-1]) ? -b_i : b_i;
            st_d.cnt   = CW'(XLEN);
            st_d.neg_q = sgn_i && (a_i[XLEN-1] ^ b_i[XLEN-1]);
            st_d.neg_r = sgn_i && a_i[XLEN-1];
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (!diff[XLEN]) begin
                st_d.rem = diff[XLEN-1:0];
                st_d.quo = {st_q.quo[XLEN-2:0], 1'b1};
            end else begin
                st_d.rem = shl[XLEN-1:0];
                st_d.quo = {st_q.quo[XLEN-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = (st_q.cnt == '0);
    assign quo_o   = st_q.neg_q ? -st_q.quo : st_q.quo;
    assign rem_o   = st_q.neg_r ? -st_q.rem : st_q.rem;

    // R8: once finished with a nonzero divisor, the magnitude remainder is below the divisor
    a_r8_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && st_q.dvs != '0) |-> (st_q.rem < st_q.dvs));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int MUL_N_LAT = 10,
    parameter int MUL_W_LAT = 20,
    parameter int DIV_N_LAT = 69,
    parameter int DIV_W_LAT = 133
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            div_i,
    input  logic            signed_i,
    input  logic            wide_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        md_op_t          op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
    } top_st_t;

    function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] x,
                                              input logic sgn, input logic wide);
        return wide ? x : {{HALF{sgn & x[HALF-1]}}, x[HALF-1:0]};
    endfunction

    function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] x, input logic wide);
        return wide ? x : {{HALF{x[HALF-1]}}, x[HALF-1:0]};
    endfunction

    top_st_t st_d, st_q;
    logic accept, fire, div_ready;
    logic [XLEN-1:0] mul_hi, mul_lo, quo, rem, a_ext, b_ext;

    muldiv_ctrl #(
        .MUL_N_LAT(MUL_N_LAT), .MUL_W_LAT(MUL_W_LAT),
        .DIV_N_LAT(DIV_N_LAT), .DIV_W_LAT(DIV_W_LAT)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .is_div_i(div_i), .wide_i(wide_i),
        .accept_o(accept), .fire_o(fire), .busy_o(busy_o), .done_o(done_o)
    );

    muldiv_mul #(.XLEN(XLEN)) mul_i (
        .sgn_i(st_q.op.sgn), .wide_i(st_q.op.wide),
        .a_i(st_q.a), .b_i(st_q.b), .hi_o(mul_hi), .lo_o(mul_lo)
    );

    muldiv_div #(.XLEN(XLEN)) div_i_u (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .sgn_i(signed_i),
        .a_i(widen(a_i, signed_i, wide_i)), .b_i(widen(b_i, signed_i, wide_i)),
        .ready_o(div_ready), .quo_o(quo), .rem_o(rem)
    );

    always_comb begin
        st_d  = st_q;
        a_ext = widen(st_q.a, st_q.op.sgn, st_q.op.wide);
        b_ext = widen(st_q.b, st_q.op.sgn, st_q.op.wide);
        if (accept) begin
            st_d.op = '{is_div: div_i, sgn: signed_i, wide: wide_i};
            st_d.a  = a_i;
            st_d.b  = b_i;
        end
        if (fire) begin
            if (!st_q.op.is_div) begin
                st_d.hi = mul_hi;
                st_d.lo = mul_lo;
            end else if (b_ext == '0) begin
                st_d.hi = narrow(a_ext, st_q.op.wide);
                st_d.lo = '1;
            end else begin
                st_d.hi = narrow(rem, st_q.op.wide);
                st_d.lo = narrow(quo, st_q.op.wide);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_o = st_q.hi;
    assign lo_o = st_q.lo;

    // R4: the iterative divider has settled before its result is taken
    a_r4_div_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.op.is_div) |-> div_ready);

    // R6: busy only rises after a sampled start
    a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R6: never busy and done together
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R11: results only change on completion
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));

    // R1: the captured operation is frozen while in flight
    a_r1_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(st_q.op));

endmodule

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;

    typedef struct packed {
        logic        d;
        logic        s;
        logic        w;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] hi;
        logic [63:0] lo;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R7 R10 narrow unsigned multiply
        '{1'b0, 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h2,
          64'h1, 64'hFFFF_FFFF_FFFF_FFFE},
        // R7 R10 narrow signed multiply, upper operand bits ignored
        '{1'b0, 1'b1, 1'b0, 64'h1234_5678_FFFF_FFFD, 64'h7,
          64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFEB},
        // R7 wide unsigned multiply
        '{1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
          64'hFFFF_FFFF_FFFF_FFFE, 64'h1},
        // R7 wide signed multiply
        '{1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
          64'h0, 64'h1},
        '{1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h4000_0000_0000_0000,
          64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
        // R8 narrow signed divide truncates toward zero
        '{1'b1, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFF9, 64'h2,
          64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFD},
        // R8 narrow unsigned divide
        '{1'b1, 1'b0, 1'b0, 64'h0000_0000_FFFF_FFF9, 64'h2,
          64'h1, 64'h7FFF_FFFC},
        // R8 wide signed divide, negative divisor
        '{1'b1, 1'b1, 1'b1, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE,
          64'h1, 64'hFFFF_FFFF_FFFF_FFFD},
        // R8 wide unsigned divide
        '{1'b1, 1'b0, 1'b1, 64'd100, 64'd7, 64'd2, 64'd14},
        '{1'b1, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h10,
          64'h0, 64'h0800_0000_0000_0000},
        // R9 wide signed divide by zero
        '{1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0,
          64'hFFFF_FFFF_FFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFF},
        // R9 R10 narrow unsigned divide by zero, upper divisor bits ignored
        '{1'b1, 1'b0, 1'b0, 64'hABCD_0000_8000_1234, 64'hFFFF_FFFF_0000_0000,
          64'hFFFF_FFFF_8000_1234, 64'hFFFF_FFFF_FFFF_FFFF},
        // R10 narrow signed overflow case
        '{1'b1, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF,
          64'h0, 64'hFFFF_FFFF_8000_0000},
        // R8 remainder follows dividend sign
        '{1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF9, 64'h3,
          64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, div = 1'b0, sgn = 1'b0, wide = 1'b0;
    logic [63:0] a = '0, b = '0;
    logic        busy, done;
    logic [63:0] hi, lo;
    int          total = 0, bad = 0;

    always #2.5 clk = ~clk;

    muldiv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .div_i(div),
        .signed_i(sgn), .wide_i(wide), .a_i(a), .b_i(b),
        .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int lat_of(input logic d, input logic w);
        return d ? (w ? 133 : 69) : (w ? 20 : 10);
    endfunction

    task automatic launch(input logic d, input logic s, input logic w,
                          input logic [63:0] x, input logic [63:0] y);
        @(negedge clk);
        div = d; sgn = s; wide = w; a = x; b = y; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat, output int busy_bad);
        lat = 0;
        busy_bad = busy ? 0 : 1;
        while (lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) break;
            if (!busy) busy_bad++;
        end
        if (busy) busy_bad++;
    endtask

    initial begin
        repeat (4000000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R6 act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, bb, dcount;
        logic [63:0] h0, l0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset busy", 64'(busy), 64'h0);
        chk("R11 reset done", 64'(done), 64'h0);
        chk("R11 reset hi", hi, 64'h0);
        chk("R11 reset lo", lo, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5 latencies, R6 busy window, R7..R10 values
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].d, VECS[i].s, VECS[i].w, VECS[i].a, VECS[i].b);
            wait_done(lat, bb);
            chk($sformatf("R2 R3 R4 R5 latency vec%0d", i), 64'(lat),
                64'(lat_of(VECS[i].d, VECS[i].w)));
            chk($sformatf("R6 busy window vec%0d", i), 64'(bb), 64'h0);
            chk($sformatf("R7 R8 R9 R10 hi vec%0d", i), hi, VECS[i].hi);
            chk($sformatf("R7 R8 R9 R10 lo vec%0d", i), lo, VECS[i].lo);
            h0 = hi; l0 = lo;
            @(negedge clk);
            chk($sformatf("R6 done pulse vec%0d", i), 64'(done), 64'h0);
            chk($sformatf("R11 hold hi vec%0d", i), hi, h0);
            chk($sformatf("R11 hold lo vec%0d", i), lo, l0);
        end

        // R1: a second start while busy is ignored
        launch(1'b0, 1'b0, 1'b0, 64'd3, 64'd5);
        repeat (3) @(negedge clk);
        div = 1'b1; wide = 1'b1; a = 64'd100; b = 64'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 4;
        while (!done && lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk("R1 first op latency kept", 64'(lat), 64'd10);
        chk("R1 first op lo", lo, 64'd15);
        chk("R1 first op hi", hi, 64'd0);
        dcount = 0;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            if (done || busy) dcount++;
        end
        chk("R1 no extra completion", 64'(dcount), 64'h0);
        chk("R1 R11 result held", lo, 64'd15);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule